// File: doc/BRIEF.md
# SCSI Target Phase Transition Sequencer

This block sits on the target side of a parallel SCSI bus and moves the bus from one information transfer phase to the next. It owns the three phase lines (message, command/data, input/output), the enable of the target's data drivers and the REQ line. A controller asks for a new phase with a one-cycle request. The block then changes the phase lines, turns the data bus around when the transfer direction changes, waits for the lines to settle and only then raises REQ to qualify the new phase.

When the direction goes from initiator-driven to target-driven, I/O is raised first. The data drivers stay off for a programmed release delay plus a settle delay, both given as clock counts, so the initiator has time to let go of the data lines. When the direction goes the other way, the drivers are switched off one cycle before I/O falls. REQ holds its level for the whole transition. A separate end-of-transfer pulse from the byte handshake logic lowers REQ once the phase is over, and that reopens the block for the next request.

Top module: `phase_turnaround_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, msg_o, cd_o, io_o, db_oe, req_o and ready are all 0.
- R2: A request codes the next phase as phase_sel[2] = MSG, phase_sel[1] = C/D, phase_sel[0] = I/O. Once the transition ends, {msg_o, cd_o, io_o} equals the requested code.
- R3: REQ does not change while a transition is in progress. Its only rise comes at the end of a transition.
- R4: The phase lines do not change while REQ is high, and they stay unchanged for at least SETTLE_CYC+1 cycles before REQ rises.
- R5: If I/O goes from 0 to 1, I/O changes in the cycle after the request is taken. db_oe rises exactly REL_CYC+SETTLE_CYC+1 cycles after I/O rises, and REQ rises SETTLE_CYC+1 cycles after db_oe.
- R6: If I/O goes from 1 to 0, db_oe falls in the cycle after the request is taken, and the phase lines change one cycle after that. db_oe is never high while io_o is low.
- R7: If I/O keeps its value, db_oe does not change, the phase lines change in the cycle after the request is taken, and REQ rises SETTLE_CYC+1 cycles after that.
- R8: A request is taken only when the block is idle and REQ is low. A request that arrives during a transition, or while REQ is high, has no effect on any output.
- R9: xfer_end lowers REQ in the next cycle when the block is idle with REQ high. At any other time it has no effect.
- R10: ready is high exactly when REQ is high and no transition is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_go | input | 1 | One-cycle request to move to phase_sel |
| phase_sel | input | 3 | Requested phase {MSG, C/D, I/O} |
| xfer_end | input | 1 | End of the current phase's transfer; lowers REQ |
| msg_o | output | 1 | MSG phase line |
| cd_o | output | 1 | C/D phase line |
| io_o | output | 1 | I/O phase line |
| db_oe | output | 1 | Target data driver enable |
| req_o | output | 1 | REQ line |
| ready | output | 1 | New phase qualified, block idle |

## Verification
Two functions can fall in the same cycle. A new phase request can coincide with an end-of-transfer pulse, and a request can arrive while a transition is still counting. The bench issues phase_go and xfer_end together while REQ is high, and it also issues them during the turnaround wait and the settle wait. A behavioural model driven by event times is compared with the outputs on every cycle. It expects the end pulse to win while REQ is high and both inputs to be ignored during a transition.

// File: rtl/phase_turnaround_seq.sv
module phase_turnaround_seq #(
  parameter int REL_CYC    = 4,
  parameter int SETTLE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_go,
  input  logic [2:0] phase_sel,
  input  logic       xfer_end,
  output logic       msg_o,
  output logic       cd_o,
  output logic       io_o,
  output logic       db_oe,
  output logic       req_o,
  output logic       ready
);
  localparam int TURN_CYC = REL_CYC + SETTLE_CYC;
  localparam int CW = $clog2(TURN_CYC + 2);
  localparam logic [CW-1:0] TURN_LD   = CW'(TURN_CYC);
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC);
  localparam logic [CW-1:0] AGE_MAX   = CW'(TURN_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_DROP, S_TURN, S_SETTLE} st_t;

  st_t          st;
  logic [2:0]   ph, nxt;
  logic [CW-1:0] cnt;
  logic         take;

  assign {msg_o, cd_o, io_o} = ph;
  assign take  = (st == S_IDLE) && phase_go && !req_o;
  assign ready = (st == S_IDLE) && req_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ph    <= '0;
      nxt   <= '0;
      cnt   <= '0;
      db_oe <= 1'b0;
      req_o <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (take) begin
            nxt <= phase_sel;
            if (ph[0] && !phase_sel[0]) begin
              db_oe <= 1'b0;
              st    <= S_DROP;
            end else if (!ph[0] && phase_sel[0]) begin
              ph  <= phase_sel;
              cnt <= TURN_LD;
              st  <= S_TURN;
            end else begin
              ph  <= phase_sel;
              cnt <= SETTLE_LD;
              st  <= S_SETTLE;
            end
          end else if (xfer_end && req_o) begin
            req_o <= 1'b0;
          end
        end
        S_DROP: begin
          ph  <= nxt;
          cnt <= SETTLE_LD;
          st  <= S_SETTLE;
        end
        S_TURN: begin
          if (cnt == '0) begin
            db_oe <= 1'b1;
            cnt   <= SETTLE_LD;
            st    <= S_SETTLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_SETTLE: begin
          if (cnt == '0) begin
            req_o <= 1'b1;
            st    <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] io_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                io_age <= '0;
    else if (!io_o)            io_age <= '0;
    else if (io_age != AGE_MAX) io_age <= io_age + 1'b1;
  end

  p_req_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(req_o) && req_o |-> $past(st) == S_SETTLE);

  p_req_idle_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TURN || st == S_DROP) |=> $stable(req_o));

  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && $past(req_o) |-> $stable(ph));

  p_oe_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(db_oe) |-> io_age == AGE_MAX);

  p_oe_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_o) |-> !db_oe && !$past(db_oe));

  p_oe_needs_io_r6: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe |-> io_o);

  p_settle_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE) |=> $stable(ph));

  p_ready_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $rose(req_o));
endmodule

// File: tb/test_phase_turnaround_seq.sv
module test_phase_turnaround_seq;
  localparam int REL = 4;
  localparam int SET = 3;
  localparam int N   = REL + SET;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, xe = 1'b0;
  logic [2:0] psel = '0;
  logic msg_o, cd_o, io_o, db_oe, req_o, ready;

  always #4 clk = ~clk;

  phase_turnaround_seq #(.REL_CYC(REL), .SETTLE_CYC(SET)) i_phase_turnaround_seq (
    .clk(clk), .rst_n(rst_n), .phase_go(go), .phase_sel(psel), .xfer_end(xe),
    .msg_o(msg_o), .cd_o(cd_o), .io_o(io_o), .db_oe(db_oe), .req_o(req_o), .ready(ready));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [2:0] m_ph = '0, m_np = '0;
  logic m_oe = 0, m_req = 0, m_busy = 0;
  int t_ph = -1, t_on = -1, t_off = -1, t_req = -1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_edge();
    cyc++;
    if (!rst_n) begin
      m_ph = '0; m_oe = 0; m_req = 0; m_busy = 0;
      t_ph = -1; t_on = -1; t_off = -1; t_req = -1;
      return;
    end
    if (!m_busy && !m_req && go) begin
      m_busy = 1; m_np = psel;
      t_ph = -1; t_on = -1; t_off = -1;
      if (!m_ph[0] && psel[0]) begin
        t_ph = cyc; t_on = cyc + N + 1; t_req = cyc + N + 1 + SET + 1;
      end else if (m_ph[0] && !psel[0]) begin
        t_off = cyc; t_ph = cyc + 1; t_req = cyc + 1 + SET + 1;
      end else begin
        t_ph = cyc; t_req = cyc + SET + 1;
      end
    end else if (!m_busy && m_req && xe) begin
      m_req = 0;
    end
    if (cyc == t_off) m_oe = 0;
    if (cyc == t_ph)  m_ph = m_np;
    if (cyc == t_on)  m_oe = 1;
    if (cyc == t_req) begin m_req = 1; m_busy = 0; end
  endtask

  task automatic compare();
    chk({msg_o, cd_o, io_o} === m_ph, "R2/R4 phase lines", int'({msg_o, cd_o, io_o}), int'(m_ph));
    chk(db_oe === m_oe, "R5/R6/R7 db_oe", int'(db_oe), int'(m_oe));
    chk(req_o === m_req, "R3/R9 req", int'(req_o), int'(m_req));
    chk(ready === (m_req && !m_busy), "R10 ready", int'(ready), int'(m_req && !m_busy));
  endtask

  task automatic step(input bit g, input logic [2:0] p, input bit e);
    go = g; psel = p; xe = e;
    @(negedge clk);
    model_edge();
    compare();
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 100) begin step(0, 3'b000, 0); n++; end
  endtask

  int n;

  initial begin
    @(negedge clk);
    rst_n = 1'b0;
    step(0, 0, 0);
    step(0, 0, 0);
    chk({msg_o, cd_o, io_o, db_oe, req_o, ready} === 6'b0, "R1 reset outputs",
        int'({msg_o, cd_o, io_o, db_oe, req_o, ready}), 0);
    rst_n = 1'b1;
    step(0, 0, 0);
    chk({msg_o, cd_o, io_o, db_oe, req_o, ready} === 6'b0, "R1 after reset",
        int'({msg_o, cd_o, io_o, db_oe, req_o, ready}), 0);

    // R7: io stays 0 (command phase)
    step(1, 3'b010, 0);
    n = 1;
    while (!req_o && n < 100) begin step(0, 0, 0); n++; end
    chk(n == SET + 2, "R7 req latency same io", n, SET + 2);
    chk(db_oe === 1'b0, "R7 db_oe unchanged", int'(db_oe), 0);

    // R8: request while REQ high, together with nothing else
    step(1, 3'b111, 0);
    chk({msg_o, cd_o, io_o} === 3'b010 && req_o, "R8 ignored while req high",
        int'({msg_o, cd_o, io_o}), 2);
    // R9: end pulse plus request in same cycle: end wins
    step(1, 3'b111, 1);
    chk(req_o === 1'b0 && {msg_o, cd_o, io_o} === 3'b010, "R9 end lowers req",
        int'(req_o), 0);

    // R5: io 0 -> 1 (status), with requests and end pulses during the wait
    step(1, 3'b011, 0);
    n = 1;
    while (!db_oe && n < 100) begin step(n == 3, 3'b000, n == 5); n++; end
    chk(n == N + 2, "R5 driver delay after io", n, N + 2);
    step(1, 3'b100, 1);
    wait_ready(n);
    chk({msg_o, cd_o, io_o} === 3'b011, "R8 mid-transition request ignored",
        int'({msg_o, cd_o, io_o}), 3);
    chk(db_oe === 1'b1, "R5 drivers on", int'(db_oe), 1);
    step(0, 0, 1);

    // R6: io 1 -> 0 (message out)
    step(1, 3'b110, 0);
    chk(db_oe === 1'b0 && io_o === 1'b1, "R6 drivers off before io falls",
        int'({db_oe, io_o}), 1);
    step(0, 0, 0);
    chk(io_o === 1'b0 && {msg_o, cd_o} === 2'b11, "R6 io falls next", int'(io_o), 0);
    wait_ready(n);
    chk(ready === 1'b1, "R10 ready after msg out", int'(ready), 1);
    step(0, 0, 1);

    // io 0 -> 1 then same io (msg in, then data in)
    step(1, 3'b111, 0);
    wait_ready(n);
    step(0, 0, 1);
    step(1, 3'b001, 0);
    chk(db_oe === 1'b1, "R7 drivers kept on", int'(db_oe), 1);
    wait_ready(n);
    chk({msg_o, cd_o, io_o} === 3'b001, "R2 data in code", int'({msg_o, cd_o, io_o}), 1);
    step(0, 0, 1);
    step(0, 0, 1);
    chk(req_o === 1'b0, "R9 end with req low ignored", int'(req_o), 0);

    // back to data out
    step(1, 3'b000, 0);
    wait_ready(n);
    chk(db_oe === 1'b0 && io_o === 1'b0, "R6 data out", int'({db_oe, io_o}), 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule